// File: doc/BRIEF.md
# RTD Conversion Limit Monitor

This block sits behind a resistance-ratio converter. Each time the converter delivers a fresh code, the block compares the code with an upper and a lower limit word. It stores the code in a result register unless an input over-range condition is active. It keeps a status byte in which every fault bit stays set once raised, so a short glitch is still visible to the host later. The fault sources are the two limit compares, an asynchronous over/undervoltage flag from the front end, and three flags produced by an on-demand wiring check.

The stored result is presented as a two-byte word. The code sits in bits [15:1] and bit 0 is a fault marker that reads 1 whenever any status bit is set. While the over-range flag is active, conversions are dropped and no limit compare is made. Storing resumes by itself once the flag goes away. A one-cycle update strobe marks every stored result.

Top module: `rtdf_guard`

## Requirements
- R1: After reset, status is 8'h00, result is 16'h0000 and result_upd is 0.
- R2: An accepted conversion whose code is greater than or equal to hi_limit[15:1] sets status bit 7 on the clock edge that accepts it. A code one below the limit leaves bit 7 clear.
- R3: An accepted conversion whose code is less than or equal to lo_limit[15:1] sets status bit 6. A code one above the limit leaves bit 6 clear.
- R4: Bit 0 of hi_limit and lo_limit has no effect on either compare.
- R5: A 1 on wire_flags[2], wire_flags[1] or wire_flags[0] during any clock edge sets status bit 5, 4 or 3 respectively.
- R6: ov_flag passes through SYNC_STAGES flip-flops. Status bit 2 is set on the edge after the synchronized flag is high, whether or not a conversion is in progress.
- R7: While the synchronized over-range flag is high, conv_valid is ignored: result keeps its code, result_upd stays 0, and no limit bit is set. Storing resumes once the flag is low.
- R8: Status bits stay set until a cycle with clear_req high. Status bits 1 and 0 always read 0.
- R9: In a cycle with clear_req high, status takes exactly the faults raised in that same cycle, so a new fault wins over the clear.
- R10: result[15:1] holds the last accepted code, and result[0] is 1 exactly when status is nonzero.
- R11: result_upd is high for one cycle, the cycle after the edge that stored a new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_valid | input | 1 | Strobe: conv_code holds a new conversion |
| conv_code | input | CODE_W | Conversion code |
| hi_limit | input | CODE_W+1 | Upper limit, code in [CODE_W:1] |
| lo_limit | input | CODE_W+1 | Lower limit, code in [CODE_W:1] |
| ov_flag | input | 1 | Asynchronous over/undervoltage flag |
| wire_flags | input | 3 | Faults from the on-demand wiring check |
| clear_req | input | 1 | Clears status for one cycle |
| status | output | 8 | Sticky fault status byte |
| result | output | CODE_W+1 | Stored code with fault marker in bit 0 |
| result_upd | output | 1 | One-cycle pulse on each stored result |

## Verification
The bench builds the block with CODE_W=15 and SYNC_STAGES=2. The 15-bit width puts the limit edges of the full code range within reach, so the equal and off-by-one cases are exact. The two-stage synchronizer gives a fixed three-edge delay from ov_flag to status bit 2. Because that delay is known, the bench can check the exact edge on which the bit appears, and it can show that conversions are dropped and that storing resumes.

// File: rtl/rtdf_pkg.sv
package rtdf_pkg;
   localparam int unsigned STAT_W    = 8;
   localparam int unsigned B_ABOVE   = 7;
   localparam int unsigned B_BELOW   = 6;
   localparam int unsigned B_WIRE_HI = 5;
   localparam int unsigned B_WIRE_LO = 3;
   localparam int unsigned B_OVUV    = 2;
   localparam int unsigned WIRE_N    = B_WIRE_HI - B_WIRE_LO + 1;
   localparam logic [STAT_W-1:0] STAT_MASK = 8'hFC;

   typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/rtdf_sync.sv
module rtdf_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else if (STAGES == 1) chain <= d;
            else chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rtdf_limit_cmp.sv
module rtdf_limit_cmp #(
   parameter int unsigned CODE_W = 15
) (
   input  logic [CODE_W-1:0] code,
   input  logic [CODE_W:0]   hi_word,
   input  logic [CODE_W:0]   lo_word,
   output logic              at_or_above,
   output logic              at_or_below
);
   logic [CODE_W-1:0] hi_code;
   logic [CODE_W-1:0] lo_code;

   assign hi_code     = hi_word[CODE_W:1];
   assign lo_code     = lo_word[CODE_W:1];
   assign at_or_above = (code >= hi_code);
   assign at_or_below = (code <= lo_code);
endmodule

// File: rtl/rtdf_status_reg.sv
module rtdf_status_reg
   import rtdf_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  stat_t set_vec,
   input  logic  clear,
   output stat_t status
);
   stat_t nxt;

   always_comb begin
      if (clear) nxt = set_vec;
      else       nxt = status | set_vec;
      nxt = nxt & STAT_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= nxt;
   end
endmodule

// File: rtl/rtdf_result_gate.sv
module rtdf_result_gate #(
   parameter int unsigned CODE_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [CODE_W-1:0] code,
   output logic [CODE_W-1:0] code_q,
   output logic              upd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         upd    <= 1'b0;
      end else begin
         upd <= take;
         if (take) code_q <= code;
      end
   end
endmodule

// File: rtl/rtdf_guard.sv
module rtdf_guard
   import rtdf_pkg::*;
#(
   parameter int unsigned CODE_W      = 15,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_valid,
   input  logic [CODE_W-1:0] conv_code,
   input  logic [CODE_W:0]   hi_limit,
   input  logic [CODE_W:0]   lo_limit,
   input  logic              ov_flag,
   input  logic [2:0]        wire_flags,
   input  logic              clear_req,
   output logic [7:0]        status,
   output logic [CODE_W:0]   result,
   output logic              result_upd
);
   localparam int unsigned RES_W = CODE_W + 1;

   generate
      if (CODE_W < 2 || CODE_W > 31) begin : g_bad_w
         $error("rtdf_guard: CODE_W out of range");
      end
      if (SYNC_STAGES > 4) begin : g_bad_s
         $error("rtdf_guard: SYNC_STAGES above 4");
      end
      if (WIRE_N != 3) begin : g_bad_n
         $error("rtdf_guard: wire flag count mismatch");
      end
   endgenerate

   logic              ov_live;
   logic              take;
   logic              above;
   logic              below;
   logic [CODE_W-1:0] code_q;
   stat_t             set_vec;
   stat_t             stat_q;

   rtdf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ov_flag), .q(ov_live)
   );

   rtdf_limit_cmp #(.CODE_W(CODE_W)) u_cmp (
      .code(conv_code), .hi_word(hi_limit), .lo_word(lo_limit),
      .at_or_above(above), .at_or_below(below)
   );

   assign take = conv_valid & ~ov_live;

   always_comb begin
      set_vec                      = '0;
      set_vec[B_ABOVE]             = take & above;
      set_vec[B_BELOW]             = take & below;
      set_vec[B_WIRE_HI:B_WIRE_LO] = wire_flags;
      set_vec[B_OVUV]              = ov_live;
   end

   rtdf_status_reg u_stat (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
      .clear(clear_req), .status(stat_q)
   );

   rtdf_result_gate #(.CODE_W(CODE_W)) u_res (
      .clk(clk), .rst_n(rst_n), .take(take), .code(conv_code),
      .code_q(code_q), .upd(result_upd)
   );

   assign status = stat_q;
   assign result = {code_q, |stat_q};

   logic [RES_W-1:0] unused_chk;
   assign unused_chk = result;
endmodule

// File: rtl/rtdf_guard_chk.sv
module rtdf_guard_chk #(
   parameter int unsigned CODE_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              conv_valid,
   input logic [CODE_W-1:0] conv_code,
   input logic [CODE_W:0]   hi_limit,
   input logic [CODE_W:0]   lo_limit,
   input logic              clear_req,
   input logic              ov_live,
   input logic [7:0]        status,
   input logic [CODE_W:0]   result,
   input logic              result_upd
);
   // R2
   above_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_valid && !ov_live && conv_code >= hi_limit[CODE_W:1]) |=> status[7]);
   // R3
   below_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_valid && !ov_live && conv_code <= lo_limit[CODE_W:1]) |=> status[6]);
   // R6
   ovuv_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ov_live |=> status[2]);
   // R7
   ovuv_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ov_live |=> (!result_upd && $stable(result[CODE_W:1])));
   // R8
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_req |=> ((status & $past(status)) == $past(status)));
   // R8
   low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[1:0] == 2'b00);
   // R10
   marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result[0] == (status != 8'h00));
   // R11
   upd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_upd |-> $past(conv_valid));
endmodule

bind rtdf_guard rtdf_guard_chk #(.CODE_W(CODE_W)) u_guard_chk (
   .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_code(conv_code),
   .hi_limit(hi_limit), .lo_limit(lo_limit), .clear_req(clear_req),
   .ov_live(ov_live), .status(status), .result(result), .result_upd(result_upd)
);

// File: tb/rtdf_guard_test.sv
module rtdf_guard_test;
   localparam int unsigned CW = 15;
   localparam int unsigned SS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          conv_valid = 1'b0;
   logic [CW-1:0] conv_code = '0;
   logic [CW:0]   hi_limit = 16'h8000;
   logic [CW:0]   lo_limit = 16'h0100;
   logic          ov_flag = 1'b0;
   logic [2:0]    wire_flags = 3'b000;
   logic          clear_req = 1'b0;
   logic [7:0]    status;
   logic [CW:0]   result;
   logic          result_upd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rtdf_guard #(.CODE_W(CW), .SYNC_STAGES(SS)) uut (
      .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_code(conv_code),
      .hi_limit(hi_limit), .lo_limit(lo_limit), .ov_flag(ov_flag),
      .wire_flags(wire_flags), .clear_req(clear_req), .status(status),
      .result(result), .result_upd(result_upd)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_conv(input logic [CW-1:0] c);
      @(negedge clk); conv_valid = 1'b1; conv_code = c;
      @(negedge clk); conv_valid = 1'b0;
   endtask

   task automatic do_clear();
      @(negedge clk); clear_req = 1'b1;
      @(negedge clk); clear_req = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 status", status, 8'h00);
      chk("R1 result", result, 16'h0000);
      chk("R1 upd", result_upd, 1'b0);
   endtask

   task automatic t_store();
      do_conv(15'h2000);
      chk("R10 result", result, 16'h4000);
      chk("R11 upd high", result_upd, 1'b1);
      chk("R2 R3 in range", status, 8'h00);
      @(negedge clk);
      chk("R11 upd one cycle", result_upd, 1'b0);
   endtask

   task automatic t_high();
      do_conv(15'h4000);
      chk("R2 equal", status, 8'h80);
      chk("R10 marker", result, 16'h8001);
      do_clear();
      chk("R8 cleared", status, 8'h00);
      do_conv(15'h3FFF);
      chk("R2 one below", status, 8'h00);
   endtask

   task automatic t_low();
      do_conv(15'h0080);
      chk("R3 equal", status, 8'h40);
      do_clear();
      do_conv(15'h0081);
      chk("R3 one above", status, 8'h00);
   endtask

   task automatic t_lsb();
      hi_limit = 16'h8001; lo_limit = 16'h0101;
      do_conv(15'h4000);
      chk("R4 hi lsb", status, 8'h80);
      do_clear();
      do_conv(15'h0080);
      chk("R4 lo lsb", status, 8'h40);
      do_clear();
      hi_limit = 16'h8000; lo_limit = 16'h0100;
   endtask

   task automatic t_wire();
      @(negedge clk); wire_flags = 3'b101;
      @(negedge clk); wire_flags = 3'b000;
      chk("R5 wire bits", status, 8'h28);
      chk("R10 marker set", {31'd0, result[0]}, 32'd1);
      repeat (4) @(negedge clk);
      chk("R8 held", status, 8'h28);
      do_clear();
      chk("R8 clear", status, 8'h00);
      chk("R10 marker clr", {31'd0, result[0]}, 32'd0);
   endtask

   task automatic t_race();
      @(negedge clk); clear_req = 1'b1; wire_flags = 3'b010;
      @(negedge clk); clear_req = 1'b0; wire_flags = 3'b000;
      chk("R9 new fault wins", status, 8'h10);
      do_clear();
   endtask

   task automatic t_ovuv();
      do_conv(15'h1234);
      chk("R10 base", result, 16'h2468);
      @(negedge clk); ov_flag = 1'b1;
      repeat (SS) @(negedge clk);
      chk("R6 not yet", status, 8'h00);
      @(negedge clk);
      chk("R6 set", status, 8'h04);
      do_conv(15'h0010);
      chk("R7 result held", result, 16'h2469);
      chk("R7 no upd", result_upd, 1'b0);
      chk("R7 no compare", status, 8'h04);
      @(negedge clk); ov_flag = 1'b0;
      repeat (SS + 1) @(negedge clk);
      do_clear();
      chk("R8 ovuv cleared", status, 8'h00);
      do_conv(15'h0ABC);
      chk("R7 resumed", result, 16'h1578);
      chk("R7 upd back", result_upd, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_store();
      t_high();
      t_low();
      t_lsb();
      t_wire();
      t_race();
      t_ovuv();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule